// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Slave

This block is the device side of a shared, open-drain, active-low control wire. The line idles high through an external pull-up. Every symbol on it is a low pulse, and the block tells symbols apart by how long the line stays low. A short pulse is a zero or a read prompt. A medium pulse is a one. A long pulse is a transaction marker. The block turns this pulse stream into command sequences. With them a host can select the device by its 4-bit address, load its control register, read the register back bit by bit, write every device on the wire at once, or restore the power-on value through a software reset. The register width is a parameter (8, 16 or 24 bits). The bits of the register steer datapath functions outside this block.

The state machine has six states. IDLE waits for a transaction marker. CODE collects the three command bits. ADDR shifts in address bits. LOAD shifts in register data, either addressed or broadcast. READ answers prompts. SKIP swallows bits that belong to another device or to an unsupported command.

The transitions are as follows. From any state, a transaction marker goes to CODE and a pulse of invalid width goes to IDLE. From CODE, the third code bit goes to IDLE for the close code (111), to ADDR for 010, to LOAD for 000, to LOAD or SKIP for 001 depending on selection, to READ or SKIP for 101 likewise, and to SKIP for any other code. Data bits keep the machine in its current state.

Pulse widths are counted in clock cycles, using a parameter for cycles per microsecond. The line input passes through a two-flop synchroniser.

Top module: `swb_slave`

## Requirements
- R1: While reset is held, and right after it, the register equals the power-on value and the line is released. The power-on value has bits 5 and 6 of every byte set and all other bits clear (0x60 per byte).
- R2: A low pulse is classified by its width in microseconds. A zero is 1 to 8, a one is 24 to 36, and a transaction marker is 80 to 120. In the READ and SKIP states the zero window extends to 12. Any other width aborts to IDLE and discards the pending operation.
- R3: Each sequence starts with a transaction marker followed by three code bits, which are compared in the order they are sent. A marker followed by 111 closes the sequence. Codes other than 010, 001, 000, 101 and 111 (including 011) have no effect on the register or on the selection.
- R4: An address sequence sends 4 bits, least significant first. At its close the device becomes selected if the last 4 bits equal dev_addr. Otherwise it becomes deselected.
- R5: Code 001 loads the register only while the device is selected. Data is sent LSB first and at least N bits are needed. When more than N bits arrive, the last N are kept. With fewer than N bits the register is unchanged.
- R6: A load takes effect only when its sequence is closed. If a different code or an invalid pulse comes first, the register is unchanged.
- R7: Code 000 (broadcast) loads the register under the same rules as R5, whatever the selection.
- R8: A committed load whose last N bits are all ones restores the power-on value and deselects the device.
- R9: In READ, each falling edge of the line presents the next register bit, starting at bit 0 and wrapping after bit N-1. A 0 bit is shown by pulling the line low. A 1 bit is shown by leaving the line released. The host samples 3.5 µs after its edge.
- R10: Each pull for a 0 bit starts only after a prompt edge and lasts exactly 10 µs.
- R11: An unselected device never pulls the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Sampled level of the shared wire (1 = high) |
| dev_addr | input | 4 | Address of this device |
| bus_pull_o | output | 1 | 1 = pull the shared wire low |
| ctrl_o | output | REG_BITS | Control register contents |

## Verification
During a read, the device's own pull and the host's prompt are low at the same time. The pulse-width meter therefore measures a single low pulse made by both drivers, and must still classify it as a prompt while the read logic times its pull. The bench releases its prompt after 2 µs and samples the wire at 3.5 µs. It counts every cycle the device pulls and checks each bit, the exact 10 µs pull length and the wrap after N prompts. It then confirms that the closing sequence that follows is still recognised. A second overlap happens when the falling edge of the closing marker arrives in READ and starts one more pull inside that marker. The check here is that the marker is still classified and the register stays unchanged.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO,
        SYM_ONE,
        SYM_TRANS,
        SYM_BAD
    } sym_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CODE,
        ST_ADDR,
        ST_LOAD,
        ST_READ,
        ST_SKIP
    } st_e;

    typedef enum logic [1:0] {
        PD_NONE,
        PD_ADDR,
        PD_LOAD
    } pend_e;

    localparam logic [2:0] CODE_ADDR  = 3'b010;
    localparam logic [2:0] CODE_LOAD  = 3'b001;
    localparam logic [2:0] CODE_READ  = 3'b101;
    localparam logic [2:0] CODE_BCAST = 3'b000;
    localparam logic [2:0] CODE_CLOSE = 3'b111;

    // Power-on value: bits 5 and 6 of every byte lane set.
    function automatic logic [31:0] reset_word(input int nbits);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < nbits && ((i % 8) == 5 || (i % 8) == 6)) begin
                w[i] = 1'b1;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/swb_pulse_meter.sv
module swb_pulse_meter
    import swb_pkg::*;
#(
    parameter int TICKS_PER_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic ext_zero_i,
    output logic fall_o,
    output logic sym_vld_o,
    output sym_e sym_kind_o
);

    localparam int Z_MIN     = TICKS_PER_US;
    localparam int Z_MAX     = 8 * TICKS_PER_US;
    localparam int Z_MAX_EXT = 12 * TICKS_PER_US;
    localparam int O_MIN     = 24 * TICKS_PER_US;
    localparam int O_MAX     = 36 * TICKS_PER_US;
    localparam int T_MIN     = 80 * TICKS_PER_US;
    localparam int T_MAX     = 120 * TICKS_PER_US;
    localparam int CNT_SAT   = T_MAX + 1;
    localparam int CNT_W     = $clog2(CNT_SAT + 1);

    logic [1:0]       sync_q;
    logic             prev_q;
    logic             s_line;
    logic [CNT_W-1:0] width_q;
    sym_e             kind_c;
    int               w_int;
    int               zero_hi;

    assign s_line = sync_q[1];

    always_comb begin
        w_int   = 32'(width_q);
        zero_hi = ext_zero_i ? Z_MAX_EXT : Z_MAX;
        if (w_int >= Z_MIN && w_int <= zero_hi) begin
            kind_c = SYM_ZERO;
        end else if (w_int >= O_MIN && w_int <= O_MAX) begin
            kind_c = SYM_ONE;
        end else if (w_int >= T_MIN && w_int <= T_MAX) begin
            kind_c = SYM_TRANS;
        end else begin
            kind_c = SYM_BAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= 2'b11;
            prev_q     <= 1'b1;
            width_q    <= '0;
            fall_o     <= 1'b0;
            sym_vld_o  <= 1'b0;
            sym_kind_o <= SYM_BAD;
        end else begin
            sync_q     <= {sync_q[0], line_i};
            prev_q     <= s_line;
            if (s_line) begin
                width_q <= '0;
            end else if (width_q != CNT_W'(CNT_SAT)) begin
                width_q <= width_q + 1'b1;
            end
            fall_o     <= prev_q & ~s_line;
            sym_vld_o  <= ~prev_q & s_line;
            sym_kind_o <= kind_c;
        end
    end

endmodule

// File: rtl/swb_readback.sv
module swb_readback #(
    parameter int DRIVE_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bit_i,
    output logic pull_o
);

    localparam int TW = $clog2(DRIVE_CYC + 1);

    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (start_i && !bit_i) begin
            tmr_q <= TW'(DRIVE_CYC);
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    assign pull_o = (tmr_q != '0);

endmodule

// File: rtl/swb_seq_fsm.sv
module swb_seq_fsm
    import swb_pkg::*;
#(
    parameter int REG_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          dev_addr_i,
    input  logic                sym_vld_i,
    input  sym_e                sym_kind_i,
    input  logic                fall_i,
    output logic [REG_BITS-1:0] ctrl_o,
    output logic                sel_o,
    output logic                ext_zero_o,
    output logic                rd_start_o,
    output logic                rd_bit_o
);

    localparam int IDX_W = $clog2(REG_BITS);
    localparam int CNT_W = $clog2(REG_BITS + 1);
    localparam logic [REG_BITS-1:0] RST_VAL = REG_BITS'(reset_word(REG_BITS));

    st_e                 st_q, st_d;
    logic [2:0]          code_q;
    logic [1:0]          code_cnt_q;
    pend_e               pend_q;
    logic [3:0]          addr_q;
    logic [2:0]          addr_cnt_q;
    logic [REG_BITS-1:0] data_q;
    logic [CNT_W-1:0]    data_cnt_q;
    logic [REG_BITS-1:0] ctrl_q;
    logic                sel_q;
    logic [IDX_W-1:0]    rd_idx_q;

    logic       bit_vld, bit_val, code_done;
    logic [2:0] code_now;

    assign bit_vld   = sym_vld_i && (sym_kind_i == SYM_ZERO || sym_kind_i == SYM_ONE);
    assign bit_val   = (sym_kind_i == SYM_ONE);
    assign code_now  = {code_q[1:0], bit_val};
    assign code_done = bit_vld && (st_q == ST_CODE) && (code_cnt_q == 2'd2);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (sym_vld_i) begin
            unique case (sym_kind_i)
                SYM_BAD:   st_d = ST_IDLE;
                SYM_TRANS: st_d = ST_CODE;
                SYM_ZERO, SYM_ONE: begin
                    if (code_done) begin
                        case (code_now)
                            CODE_CLOSE: st_d = ST_IDLE;
                            CODE_ADDR:  st_d = ST_ADDR;
                            CODE_BCAST: st_d = ST_LOAD;
                            CODE_LOAD:  st_d = sel_q ? ST_LOAD : ST_SKIP;
                            CODE_READ:  st_d = sel_q ? ST_READ : ST_SKIP;
                            default:    st_d = ST_SKIP;
                        endcase
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Shift registers, pending operation and commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q     <= '0;
            code_cnt_q <= '0;
            pend_q     <= PD_NONE;
            addr_q     <= '0;
            addr_cnt_q <= '0;
            data_q     <= '0;
            data_cnt_q <= '0;
            ctrl_q     <= RST_VAL;
            sel_q      <= 1'b0;
            rd_idx_q   <= '0;
        end else begin
            if (rd_start_o) begin
                rd_idx_q <= (rd_idx_q == IDX_W'(REG_BITS - 1)) ? '0 : rd_idx_q + 1'b1;
            end
            if (sym_vld_i) begin
                unique case (sym_kind_i)
                    SYM_BAD: begin
                        pend_q <= PD_NONE;
                    end
                    SYM_TRANS: begin
                        code_cnt_q <= '0;
                        if (st_q == ST_ADDR) begin
                            pend_q <= PD_ADDR;
                        end else if (st_q == ST_LOAD) begin
                            pend_q <= PD_LOAD;
                        end else begin
                            pend_q <= PD_NONE;
                        end
                    end
                    SYM_ZERO, SYM_ONE: begin
                        case (st_q)
                            ST_CODE: begin
                                code_q     <= code_now;
                                code_cnt_q <= code_cnt_q + 1'b1;
                                if (code_cnt_q == 2'd2) begin
                                    addr_cnt_q <= '0;
                                    data_cnt_q <= '0;
                                    rd_idx_q   <= '0;
                                    pend_q     <= PD_NONE;
                                    if (code_now == CODE_CLOSE) begin
                                        if (pend_q == PD_ADDR) begin
                                            sel_q <= (addr_cnt_q == 3'd4) && (addr_q == dev_addr_i);
                                        end else if (pend_q == PD_LOAD &&
                                                     data_cnt_q == CNT_W'(REG_BITS)) begin
                                            if (&data_q) begin
                                                ctrl_q <= RST_VAL;
                                                sel_q  <= 1'b0;
                                            end else begin
                                                ctrl_q <= data_q;
                                            end
                                        end
                                    end
                                end
                            end
                            ST_ADDR: begin
                                addr_q <= {bit_val, addr_q[3:1]};
                                if (addr_cnt_q != 3'd4) begin
                                    addr_cnt_q <= addr_cnt_q + 1'b1;
                                end
                            end
                            ST_LOAD: begin
                                data_q <= {bit_val, data_q[REG_BITS-1:1]};
                                if (data_cnt_q != CNT_W'(REG_BITS)) begin
                                    data_cnt_q <= data_cnt_q + 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        ctrl_o     = ctrl_q;
        sel_o      = sel_q;
        ext_zero_o = (st_q == ST_READ) || (st_q == ST_SKIP);
        rd_start_o = fall_i && (st_q == ST_READ);
        rd_bit_o   = ctrl_q[rd_idx_q];
    end

endmodule

// File: rtl/swb_slave.sv
module swb_slave
    import swb_pkg::*;
#(
    parameter int REG_BITS     = 8,
    parameter int TICKS_PER_US = 250
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_i,
    input  logic [3:0]          dev_addr,
    output logic                bus_pull_o,
    output logic [REG_BITS-1:0] ctrl_o
);

    localparam int DRIVE_CYC = 10 * TICKS_PER_US;

    logic fall_evt;
    logic sym_vld;
    sym_e sym_kind;
    logic ext_zero;
    logic dev_sel;
    logic rd_start;
    logic rd_bit;

    swb_pulse_meter #(
        .TICKS_PER_US(TICKS_PER_US)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (bus_i),
        .ext_zero_i (ext_zero),
        .fall_o     (fall_evt),
        .sym_vld_o  (sym_vld),
        .sym_kind_o (sym_kind)
    );

    swb_seq_fsm #(
        .REG_BITS(REG_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_addr_i (dev_addr),
        .sym_vld_i  (sym_vld),
        .sym_kind_i (sym_kind),
        .fall_i     (fall_evt),
        .ctrl_o     (ctrl_o),
        .sel_o      (dev_sel),
        .ext_zero_o (ext_zero),
        .rd_start_o (rd_start),
        .rd_bit_o   (rd_bit)
    );

    swb_readback #(
        .DRIVE_CYC(DRIVE_CYC)
    ) u_rdbk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rd_start),
        .bit_i   (rd_bit),
        .pull_o  (bus_pull_o)
    );

endmodule

// File: rtl/swb_slave_chk.sv
module swb_slave_chk
    import swb_pkg::*;
#(
    parameter int REG_BITS  = 8,
    parameter int DRIVE_CYC = 2500
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_pull_o,
    input logic [REG_BITS-1:0] ctrl_o,
    input logic                sym_vld,
    input sym_e                sym_kind,
    input logic                fall_evt,
    input logic                dev_sel
);

    localparam int RW = $clog2(DRIVE_CYC + 2);
    localparam logic [REG_BITS-1:0] RST_VAL = REG_BITS'(reset_word(REG_BITS));

    logic [RW-1:0] run_q;
    logic          rst_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!bus_pull_o) begin
            run_q <= '0;
        end else if (run_q != RW'(DRIVE_CYC + 1)) begin
            run_q <= run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    always @(posedge clk) begin
        if (!rst_n && rst_seen_q) begin
            assert_reset_value_R1: assert (ctrl_o == RST_VAL && !bus_pull_o)
                else $error("reset value wrong");
        end
    end

    assert_pull_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_o |-> (run_q < RW'(DRIVE_CYC)))
        else $error("pull longer than drive window");

    assert_pull_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_pull_o) |-> $past(fall_evt))
        else $error("pull started without prompt edge");

    assert_pull_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_o |-> dev_sel)
        else $error("pull while unselected");

    assert_commit_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> $past(sym_vld && sym_kind == SYM_ONE))
        else $error("register changed outside a close bit");

endmodule

bind swb_slave swb_slave_chk #(
    .REG_BITS (REG_BITS),
    .DRIVE_CYC(DRIVE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_pull_o (bus_pull_o),
    .ctrl_o     (ctrl_o),
    .sym_vld    (sym_vld),
    .sym_kind   (sym_kind),
    .fall_evt   (fall_evt),
    .dev_sel    (dev_sel)
);

// File: tb/tb_swb_slave.sv
module tb_swb_slave;

    localparam int N   = 8;
    localparam int US  = 4;
    localparam int GAP = 8;
    localparam logic [3:0] MY_ADDR = 4'hA;
    localparam logic [N-1:0] PON = 8'h60;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_low = 1'b0;
    logic         bus;
    logic         pull;
    logic [N-1:0] ctrl;
    logic [3:0]   addr = MY_ADDR;

    int n_chk = 0;
    int n_fail = 0;
    int w0 = 5 * US;
    int w1 = 30 * US;
    int wt = 100 * US;
    logic [N-1:0] exp_q;
    bit done = 0;

    always #2 clk = ~clk;

    assign bus = ~(host_low | pull);

    swb_slave #(.REG_BITS(N), .TICKS_PER_US(US)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_i      (bus),
        .dev_addr   (addr),
        .bus_pull_o (pull),
        .ctrl_o     (ctrl)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic low_pulse(input int cyc);
        @(negedge clk);
        host_low = 1'b1;
        repeat (cyc) @(negedge clk);
        host_low = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        low_pulse(b ? w1 : w0);
    endtask

    task automatic send_code(input logic [2:0] c);
        low_pulse(wt);
        send_bit(c[2]);
        send_bit(c[1]);
        send_bit(c[0]);
    endtask

    task automatic close_seq();
        send_code(3'b111);
        repeat (8) @(negedge clk);
    endtask

    task automatic do_addr(input logic [3:0] a);
        send_code(3'b010);
        for (int i = 0; i < 4; i++) send_bit(a[i]);
        close_seq();
    endtask

    task automatic do_data(input logic [2:0] c, input logic [31:0] v, input int n);
        send_code(c);
        for (int i = 0; i < n; i++) send_bit(v[i]);
        close_seq();
    endtask

    task automatic do_read(input int n, output logic [63:0] got, output int pulls);
        got = '0;
        pulls = 0;
        send_code(3'b101);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_low = 1'b1;
            for (int c = 1; c <= 15 * US; c++) begin
                @(negedge clk);
                if (pull) pulls++;
                if (c == 2 * US) host_low = 1'b0;
                if (c == 14) got[i] = bus;
            end
        end
        close_seq();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic [63:0] expb;
        int pulls;
        int zeros;
        logic [N-1:0] vals [8];

        repeat (10) @(negedge clk);
        chk(ctrl, PON, "R1 reset value");
        chk(pull, 0, "R1 line released");
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(ctrl, PON, "R1 after reset");

        // R7: broadcast while unselected
        do_data(3'b000, 32'h5A, N);
        exp_q = 8'h5A;
        chk(ctrl, exp_q, "R7 broadcast load");

        // R5: addressed load while unselected is ignored
        do_data(3'b001, 32'h33, N);
        chk(ctrl, exp_q, "R5 unselected load ignored");

        // R4: address sweep
        for (int a = 0; a < 16; a++) begin
            do_addr(4'(a));
            do_data(3'b001, 32'h20 | a, N);
            if (4'(a) == MY_ADDR) exp_q = 8'(32'h20 | a);
            chk(ctrl, exp_q, "R4 address match");
        end

        // R5: over-length and short loads
        do_addr(MY_ADDR);
        do_data(3'b001, 32'hABC, 12);
        exp_q = 8'hAB;
        chk(ctrl, exp_q, "R5 last N bits kept");
        do_data(3'b001, 32'h11, N - 1);
        chk(ctrl, exp_q, "R5 short load ignored");

        // R6: unclosed load, then another sequence
        send_code(3'b001);
        for (int i = 0; i < N; i++) send_bit(i[0]);
        do_addr(MY_ADDR);
        chk(ctrl, exp_q, "R6 unclosed load discarded");

        // R6/R2: load aborted by invalid pulse
        send_code(3'b001);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        low_pulse(60 * US);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        close_seq();
        chk(ctrl, exp_q, "R6 aborted load discarded");

        // R2: window edges accepted
        w0 = 1 * US; w1 = 24 * US; wt = 80 * US;
        do_data(3'b001, 32'h96, N);
        exp_q = 8'h96;
        chk(ctrl, exp_q, "R2 lower window edges");
        w0 = 8 * US; w1 = 36 * US; wt = 120 * US;
        do_data(3'b001, 32'h69, N);
        exp_q = 8'h69;
        chk(ctrl, exp_q, "R2 upper window edges");
        w0 = 5 * US; w1 = 30 * US; wt = 100 * US;

        // R2: out-of-window widths abort
        send_code(3'b001);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        low_pulse(US - 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        close_seq();
        chk(ctrl, exp_q, "R2 too-short pulse aborts");
        send_code(3'b001);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        low_pulse(37 * US);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        close_seq();
        chk(ctrl, exp_q, "R2 37us pulse aborts");
        send_code(3'b001);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        low_pulse(9 * US);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        close_seq();
        chk(ctrl, exp_q, "R2 9us pulse aborts outside read");

        // R9/R10: load and read back with wrap
        vals = '{8'h00, 8'hFE, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'h7F};
        foreach (vals[k]) begin
            do_data(3'b001, {24'h0, vals[k]}, N);
            exp_q = vals[k];
            chk(ctrl, exp_q, "R5 load before read");
            do_read(N + 4, got, pulls);
            expb = '0;
            zeros = 0;
            for (int i = 0; i < N + 4; i++) begin
                expb[i] = vals[k][i % N];
                if (!vals[k][i % N]) zeros++;
            end
            chk(got, expb, "R9 read bits with wrap");
            chk(pulls, zeros * 10 * US, "R10 pull length");
            chk(ctrl, exp_q, "R9 read leaves register");
        end

        // R3: unsupported code has no effect
        do_data(3'b011, 32'h0F, N);
        chk(ctrl, exp_q, "R3 code 011 ignored");
        do_data(3'b001, 32'h42, N);
        exp_q = 8'h42;
        chk(ctrl, exp_q, "R3 selection kept after 011");

        // R11: unselected read never pulls
        do_addr(4'h3);
        do_read(N, got, pulls);
        chk(got[N-1:0], {N{1'b1}}, "R11 unselected read bits");
        chk(pulls, 0, "R11 unselected pull count");

        // R8: software reset via addressed load
        do_addr(MY_ADDR);
        do_data(3'b001, 32'hFF, N);
        chk(ctrl, PON, "R8 all-ones restores power-on value");
        do_data(3'b001, 32'h12, N);
        chk(ctrl, PON, "R8 selection cleared");

        // R7/R8: broadcast load and broadcast reset
        do_data(3'b000, 32'h3C, N);
        chk(ctrl, 8'h3C, "R7 broadcast while unselected");
        do_data(3'b000, 32'h3FF, 10);
        chk(ctrl, PON, "R8 broadcast all ones");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule